// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps physical addresses from a processor onto device targets through a bank of programmable windows. Each window names a target ID and an attribute byte. It covers a base address and a power-of-two span measured in 64 KiB units, and it is switched on by an enable bit. Software programs the windows through a simple word-wide register port. The decision of which window to use and the check for overlaps stay in software.

A lookup port takes a 36-bit address. One clock later it reports whether a window matched, which window matched, that window's target and attribute, and the translated address. The lower-numbered windows can redirect their span to a different physical region. The higher-numbered windows forward the address unchanged.

The register space has two regions. The wide windows come first, with four registers each. A 16-byte gap follows, and then the narrow windows with two registers each.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every window is disabled, every lookup misses, and every register reads as zero.
- R2: The window control word holds the enable in bit 0, the target ID in bits 7:4 and the attribute in bits 15:8. Bits 31:16 give the span as (field+1) × 64 KiB. Bits 3:1 are not stored and read as zero.
- R3: The window base word holds address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0. All other bits read as zero.
- R4: Windows 0 to 7 sit at byte offset win×0x10, with control at +0x0, base at +0x4, remap-low at +0x8 and remap-high at +0xC. Windows 8 to 19 sit at 0x90+(win−8)×8, with control at +0x0 and base at +0x4.
- R5: Offsets 0x80 to 0x8F, and every offset from 0xF0 upward, read as zero. Writes to them change no window.
- R6: A window that is enabled, with a base aligned to its span, matches when base ≤ addr < base+span. All 36 address bits take part in the match. A window whose enable bit is clear never matches.
- R7: When several enabled windows match, the lowest-numbered one is reported.
- R8: On a miss, hit, target, attribute and window index are all zero, and the translated address equals the lookup address.
- R9: For windows 0 to 7 the translated address is ({remapHigh[3:0], remapLow[31:16], 16'h0} & ~(span−1)) | (addr & (span−1)). Remap-low bits 15:0 and remap-high bits 31:4 read as zero.
- R10: For windows 8 to 19 the translated address equals the lookup address.
- R11: Lookup results appear exactly one clock edge after the address is presented and hold until the next edge.
- R12: Writing zero to a window's control, base and remap words disables that window. The lookup then falls through to the next matching window, or misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset (bits 1:0 ignored) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| lkAddr | input | 36 | Address to decode |
| lkHit | output | 1 | A window matched |
| lkTarget | output | 4 | Target ID of the matching window |
| lkAttr | output | 8 | Attribute of the matching window |
| lkWin | output | 5 | Index of the matching window |
| lkXlat | output | 36 | Translated address |

## Verification
Every stored field can be read back at once through the register port. A decode error in the irregular map therefore shows in the same cycle: a value appears in the wrong window or in the gap, or bits that are not stored read back non-zero. A wrong comparison, a wrong priority or a wrong remap merge shows on the lookup outputs one edge after the address is driven. The bench uses overlapping windows and addresses at the first and last byte of a span, so that an off-by-one or priority-inversion fault changes the reported window, target or translated address.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

  localparam int WIN_SEL_W = 8;

  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_BASE  = 2'd1,
    FLD_RMPLO = 2'd2,
    FLD_RMPHI = 2'd3
  } regField_e;

  // Strobes from the register decoder to the window datapath
  typedef struct packed {
    logic                 sel;   // offset maps onto an implemented register
    logic                 wr;    // write that register this cycle
    logic [WIN_SEL_W-1:0] win;   // window index
    regField_e            field; // which register of the window
  } regStrobe_t;

endpackage

// File: rtl/addr_win_ctrl.sv
module addr_win_ctrl
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int REG_AW    = 8
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strb
);

  localparam logic [31:0] WIDE_END    = 32'(NUM_REMAP * 16);
  localparam logic [31:0] NARROW_BASE = WIDE_END + 32'd16;
  localparam logic [31:0] NARROW_END  = NARROW_BASE + 32'((NUM_WIN - NUM_REMAP) * 8);

  logic [31:0] offs;

  always_comb begin
    offs  = 32'(regAddr);
    strb  = '0;
    if (offs < WIDE_END) begin
      strb.sel   = 1'b1;
      strb.win   = WIN_SEL_W'(offs >> 4);
      strb.field = regField_e'(offs[3:2]);
    end else if (offs >= NARROW_BASE && offs < NARROW_END) begin
      strb.sel   = 1'b1;
      strb.win   = WIN_SEL_W'(32'(NUM_REMAP) + ((offs - NARROW_BASE) >> 3));
      strb.field = offs[2] ? FLD_BASE : FLD_CTRL;
    end
    strb.wr = regWrEn & strb.sel;
  end

endmodule

// File: rtl/addr_win_dpath.sv
module addr_win_dpath
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int WIN_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [3:0]        lkTarget,
  output logic [7:0]        lkAttr,
  output logic [WIN_W-1:0]  lkWin,
  output logic [ADDR_W-1:0] lkXlat
);

  localparam int HI_W = ADDR_W - 32;

  logic              winEn   [NUM_WIN];
  logic [3:0]        winTgt  [NUM_WIN];
  logic [7:0]        winAttr [NUM_WIN];
  logic [15:0]       winSize [NUM_WIN];
  logic [15:0]       baseLo  [NUM_WIN];
  logic [HI_W-1:0]   baseHi  [NUM_WIN];
  logic [NUM_WIN-1:0] hitVec;
  logic [ADDR_W-1:0] xlatVec [NUM_WIN];
  logic [31:0]       rdVec   [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic              selWin;
    logic [ADDR_W-1:0] spanMask;
    logic [ADDR_W-1:0] baseFull;
    logic [31:0]       ctrlWord;
    logic [31:0]       baseWord;

    assign selWin   = strb.sel && (strb.win == WIN_SEL_W'(g));
    assign spanMask = {{HI_W{1'b0}}, winSize[g], 16'hFFFF};
    assign baseFull = {baseHi[g], baseLo[g], 16'h0000};
    assign ctrlWord = {winSize[g], winAttr[g], winTgt[g], 3'b000, winEn[g]};
    assign baseWord = {baseLo[g], {(16 - HI_W){1'b0}}, baseHi[g]};
    assign hitVec[g] = winEn[g] && ((lkAddr & ~spanMask) == (baseFull & ~spanMask));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winEn[g]   <= 1'b0;
        winTgt[g]  <= '0;
        winAttr[g] <= '0;
        winSize[g] <= '0;
        baseLo[g]  <= '0;
        baseHi[g]  <= '0;
      end else if (strb.wr && selWin) begin
        if (strb.field == FLD_CTRL) begin
          winEn[g]   <= regWrData[0];
          winTgt[g]  <= regWrData[7:4];
          winAttr[g] <= regWrData[15:8];
          winSize[g] <= regWrData[31:16];
        end
        if (strb.field == FLD_BASE) begin
          baseLo[g] <= regWrData[31:16];
          baseHi[g] <= regWrData[HI_W-1:0];
        end
      end
    end

    if (g < NUM_REMAP) begin : g_remap
      logic [15:0]       rmpLo;
      logic [HI_W-1:0]   rmpHi;
      logic [ADDR_W-1:0] rmpFull;

      assign rmpFull = {rmpHi, rmpLo, 16'h0000};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rmpLo <= '0;
          rmpHi <= '0;
        end else if (strb.wr && selWin) begin
          if (strb.field == FLD_RMPLO) rmpLo <= regWrData[31:16];
          if (strb.field == FLD_RMPHI) rmpHi <= regWrData[HI_W-1:0];
        end
      end

      assign xlatVec[g] = (rmpFull & ~spanMask) | (lkAddr & spanMask);

      always_comb begin
        rdVec[g] = '0;
        if (selWin) begin
          case (strb.field)
            FLD_CTRL:  rdVec[g] = ctrlWord;
            FLD_BASE:  rdVec[g] = baseWord;
            FLD_RMPLO: rdVec[g] = {rmpLo, 16'h0000};
            FLD_RMPHI: rdVec[g] = {{(32 - HI_W){1'b0}}, rmpHi};
            default:   rdVec[g] = '0;
          endcase
        end
      end
    end else begin : g_plain
      assign xlatVec[g] = lkAddr;

      always_comb begin
        rdVec[g] = '0;
        if (selWin) begin
          if (strb.field == FLD_CTRL) rdVec[g] = ctrlWord;
          else if (strb.field == FLD_BASE) rdVec[g] = baseWord;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_WIN; i++) regRdData = regRdData | rdVec[i];
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit
  logic              nHit;
  logic [3:0]        nTgt;
  logic [7:0]        nAttr;
  logic [WIN_W-1:0]  nWin;
  logic [ADDR_W-1:0] nXlat;

  always_comb begin
    nHit  = 1'b0;
    nTgt  = '0;
    nAttr = '0;
    nWin  = '0;
    nXlat = lkAddr;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        nHit  = 1'b1;
        nTgt  = winTgt[i];
        nAttr = winAttr[i];
        nWin  = WIN_W'(i);
        nXlat = xlatVec[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit    <= 1'b0;
      lkTarget <= '0;
      lkAttr   <= '0;
      lkWin    <= '0;
      lkXlat   <= '0;
    end else begin
      lkHit    <= nHit;
      lkTarget <= nTgt;
      lkAttr   <= nAttr;
      lkWin    <= nWin;
      lkXlat   <= nXlat;
    end
  end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int REG_AW    = 8,
  parameter int WIN_W     = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [3:0]        lkTarget,
  output logic [7:0]        lkAttr,
  output logic [WIN_W-1:0]  lkWin,
  output logic [ADDR_W-1:0] lkXlat
);

  regStrobe_t strb;

  addr_win_ctrl #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
  ) i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb)
  );

  addr_win_dpath #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W), .WIN_W(WIN_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .lkAddr(lkAddr), .lkHit(lkHit),
    .lkTarget(lkTarget), .lkAttr(lkAttr), .lkWin(lkWin), .lkXlat(lkXlat)
  );

endmodule

// File: rtl/addr_win_decoder_chk.sv
module addr_win_decoder_chk #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int ADDR_W    = 36,
  parameter int REG_AW    = 8,
  parameter int WIN_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic [3:0]        lkTarget,
  input logic [7:0]        lkAttr,
  input logic [WIN_W-1:0]  lkWin,
  input logic [ADDR_W-1:0] lkXlat
);

  localparam logic [31:0] HOLE_LO = 32'(NUM_REMAP * 16);
  localparam logic [31:0] HOLE_HI = HOLE_LO + 32'd16;
  localparam logic [31:0] MAP_END = HOLE_HI + 32'((NUM_WIN - NUM_REMAP) * 8);

  logic started;
  logic unmapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  assign unmapped = (32'(regAddr) >= HOLE_LO && 32'(regAddr) < HOLE_HI) ||
                    (32'(regAddr) >= MAP_END);

  // R5: unmapped offsets read as zero
  a_r5_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> regRdData == 32'h0);

  // R8: a miss carries no target, attribute or window index
  a_r8_miss_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkTarget == 4'h0 && lkAttr == 8'h0 && lkWin == '0));

  // R8 and R11: a miss forwards the address presented one edge earlier
  a_r8_miss_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (started && !lkHit) |=> (lkHit || lkXlat == $past(lkAddr)));

  // R10: narrow windows never translate
  a_r10_plain_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkWin >= WIN_W'(NUM_REMAP)) |-> lkXlat == $past(lkAddr));

  // R9: the 64 KiB page offset always survives translation
  a_r9_low_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    (started && lkHit) |-> lkXlat[15:0] == $past(lkAddr[15:0]));

  // R6: a reported window index is always an existing window
  a_r6_win_in_range: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkWin < WIN_W'(NUM_WIN));

endmodule

bind addr_win_decoder addr_win_decoder_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W),
  .REG_AW(REG_AW), .WIN_W(WIN_W)
) i_chk (.*);

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [35:0] lkAddr = '0;
  logic        lkHit;
  logic [3:0]  lkTarget;
  logic [7:0]  lkAttr;
  logic [4:0]  lkWin;
  logic [35:0] lkXlat;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  addr_win_decoder i_addr_win_decoder (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkTarget(lkTarget), .lkAttr(lkAttr), .lkWin(lkWin),
    .lkXlat(lkXlat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, 64'(regRdData), 64'(exp));
  endtask

  task automatic look(input logic [35:0] a);
    @(negedge clk);
    lkAddr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic lookChk(input string req, input logic [35:0] a, input logic hit,
                         input logic [4:0] win, input logic [3:0] tgt,
                         input logic [7:0] attr, input logic [35:0] xl);
    look(a);
    chk({req, " hit"},    64'(lkHit),    64'(hit));
    chk({req, " win"},    64'(lkWin),    64'(win));
    chk({req, " target"}, 64'(lkTarget), 64'(tgt));
    chk({req, " attr"},   64'(lkAttr),   64'(attr));
    chk({req, " xlat"},   64'(lkXlat),   64'(xl));
  endtask

  task automatic testReset();
    rdChk("R1 ctrl0", 8'h00, 32'h0);
    rdChk("R1 base9", 8'h9C, 32'h0);
    rdChk("R1 rmphi7", 8'h7C, 32'h0);
    lookChk("R1 lookup", 36'h0_0000_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_0000_0000);
  endtask

  task automatic testLayout();
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdChk("R2 ctrl unused bits", 8'h00, 32'hFFFF_FFF1);
    wrReg(8'h9C, 32'hFFFF_FFFF);
    rdChk("R3 base unused bits", 8'h9C, 32'hFFFF_000F);
    wrReg(8'h38, 32'hFFFF_FFFF);
    rdChk("R9 remap-low readback", 8'h38, 32'hFFFF_0000);
    wrReg(8'h3C, 32'hFFFF_FFFF);
    rdChk("R9 remap-high readback", 8'h3C, 32'h0000_000F);
    wrReg(8'hE8, 32'h1234_5670);
    rdChk("R4 window 19 ctrl", 8'hE8, 32'h1234_5670);
    wrReg(8'hEC, 32'h00AB_0002);
    rdChk("R4 window 19 base", 8'hEC, 32'h00AB_0002);
    rdChk("R4 window 18 untouched", 8'hE0, 32'h0);
    wrReg(8'h00, 32'h0); wrReg(8'h9C, 32'h0); wrReg(8'h38, 32'h0);
    wrReg(8'h3C, 32'h0); wrReg(8'hE8, 32'h0); wrReg(8'hEC, 32'h0);
    rdChk("R12 cleared ctrl0", 8'h00, 32'h0);
  endtask

  task automatic testHole();
    for (int k = 0; k < 4; k++) wrReg(8'h80 + 8'(k * 4), 32'hFFFF_FFFF);
    wrReg(8'hF0, 32'hFFFF_FFFF);
    wrReg(8'hFC, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) rdChk("R5 hole read", 8'h80 + 8'(k * 4), 32'h0);
    rdChk("R5 beyond map", 8'hF0, 32'h0);
    rdChk("R5 win7 rmphi unchanged", 8'h7C, 32'h0);
    rdChk("R5 win8 ctrl unchanged", 8'h90, 32'h0);
    rdChk("R5 win8 base unchanged", 8'h94, 32'h0);
    lookChk("R5 no window opened", 36'h0_8000_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_8000_0000);
  endtask

  task automatic testMatch();
    wrReg(8'h98, 32'h000F_3C51);   // window 9: 1 MiB, attr 3C, target 5
    wrReg(8'h9C, 32'h2000_0001);   // base 0x1_2000_0000
    lookChk("R6 first byte", 36'h1_2000_0000, 1'b1, 5'd9, 4'h5, 8'h3C, 36'h1_2000_0000);
    lookChk("R10 last byte", 36'h1_200F_FFFF, 1'b1, 5'd9, 4'h5, 8'h3C, 36'h1_200F_FFFF);
    lookChk("R8 one past end", 36'h1_2010_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h1_2010_0000);
    lookChk("R6 one below base", 36'h1_1FFF_FFFF, 1'b0, 5'd0, 4'h0, 8'h00, 36'h1_1FFF_FFFF);
    lookChk("R6 high bits differ", 36'h0_2000_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_2000_0000);
  endtask

  task automatic testRemap();
    wrReg(8'h20, 32'h0001_AA21);   // window 2: 128 KiB, attr AA, target 2
    wrReg(8'h24, 32'h4000_0000);
    wrReg(8'h28, 32'h1234_FFFF);
    wrReg(8'h2C, 32'h0000_0003);
    rdChk("R9 remap-low low half dropped", 8'h28, 32'h1234_0000);
    lookChk("R9 translated", 36'h0_4001_ABCD, 1'b1, 5'd2, 4'h2, 8'hAA, 36'h3_1235_ABCD);
    lookChk("R9 outside span", 36'h0_4002_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_4002_0000);
  endtask

  task automatic testPriority();
    wrReg(8'h50, 32'h0000_0171);   // window 5: 64 KiB, attr 01, target 7
    wrReg(8'h54, 32'h2000_0001);
    wrReg(8'h58, 32'h2000_0000);
    wrReg(8'h5C, 32'h0000_0001);
    lookChk("R7 lower window wins", 36'h1_2000_1000, 1'b1, 5'd5, 4'h7, 8'h01, 36'h1_2000_1000);
    lookChk("R7 only upper window", 36'h1_2001_0000, 1'b1, 5'd9, 4'h5, 8'h3C, 36'h1_2001_0000);
    wrReg(8'h54, 32'h0); wrReg(8'h50, 32'h0); wrReg(8'h58, 32'h0); wrReg(8'h5C, 32'h0);
    rdChk("R12 window 5 ctrl cleared", 8'h50, 32'h0);
    lookChk("R12 falls through", 36'h1_2000_1000, 1'b1, 5'd9, 4'h5, 8'h3C, 36'h1_2000_1000);
  endtask

  task automatic testLatency();
    look(36'h0_0000_0000);
    chk("R11 start from miss", 64'(lkHit), 64'd0);
    @(negedge clk);
    lkAddr = 36'h0_4000_0010;
    #1 chk("R11 no change before edge", 64'(lkHit), 64'd0);
    @(posedge clk);
    #1 chk("R11 hit after one edge", 64'(lkHit), 64'd1);
    chk("R11 xlat after one edge", 64'(lkXlat), 64'h3_1234_0010);
    @(negedge clk);
    lkAddr = 36'h0_5000_0000;
    #1 chk("R11 hit held before edge", 64'(lkHit), 64'd1);
    @(posedge clk);
    #1 chk("R11 miss after one edge", 64'(lkHit), 64'd0);
  endtask

  task automatic testDisabled();
    wrReg(8'hA0, 32'h000F_3C50);   // window 10 programmed but enable clear
    wrReg(8'hA4, 32'h7000_0000);
    lookChk("R6 disabled window", 36'h0_7000_0000, 1'b0, 5'd0, 4'h0, 8'h00, 36'h0_7000_0000);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLayout();
    testHole();
    testMatch();
    testRemap();
    testPriority();
    testLatency();
    testDisabled();
    finishRun();
  end

endmodule